// File: doc/BRIEF.md
# Hexadecimal Floating-Point Compare Unit

This unit orders an accumulator value against a second value. Both are 32-bit words in hexadecimal floating-point form: a sign bit, an excess-64 exponent that counts powers of sixteen, and a six-digit hex fraction. It does not compare the fields directly. It inverts the sign of the second value and runs the pair through the align-and-add path that an adder would use. It then reads the relation from the two's-complement sum of the aligned fractions. No result word is stored, and a zero operand gets no special treatment.

A caller presents both words and pulses the start strobe for one clock. The words are captured on that edge. The smaller operand is then moved right one hex digit per clock, or in a single step in the barrel variant, until the exponents agree. The sum is formed and three registered flags are set: logical greater, arithmetic greater and equal. A one-clock done pulse marks the moment the flags change. The flags then hold until the next done.

Top module: `hfc_compare`

## Requirements
- R1: While reset is asserted, and after it is released with no start, `done_o`, `lgt_o`, `agt_o` and `eq_o` are all 0.
- R2: `eq_o` is 1 exactly when the aligned fraction sum is zero. Two identical words give `eq_o`=1, `lgt_o`=0 and `agt_o`=0.
- R3: `agt_o` is 1 exactly when the aligned sum, read as signed, is greater than zero, that is when the accumulator ranks above the second value.
- R4: `lgt_o` is 1 exactly when the aligned sum is nonzero, read as unsigned. It is never 1 together with `eq_o`.
- R5: A word has its sign in bit 31, its exponent in bits 30:24 and its fraction in bits 23:0. The fraction becomes a two's-complement value, negative when the sign bit is 1. The sign of the second value is inverted before alignment, so the sum is accumulator minus second value.
- R6: The operand with the smaller exponent is moved right one hex digit per exponent step by an arithmetic shift. Digits shifted out are lost, so the result rounds toward minus infinity. Only then are the two signed fractions added.
- R7: When the exponents differ by CUTOFF (6) or more, the fraction of the smaller-exponent operand is replaced by zero before the add.
- R8: A zero word gets no shortcut. A word with a zero fraction still takes part in alignment with its exponent field, so all-zeros acts as +0 times 16^-64. A zero fraction with a large exponent can push a small nonzero operand past the cutoff.
- R9: `done_o` is high for exactly one clock. It rises N+2 clocks after the start edge. N is 0 when the exponents are equal, 1 when the gap reaches the cutoff or the barrel variant is built, and otherwise the exponent gap.
- R10: The flags change only in the cycle `done_o` is high and hold between results. A start raised while a comparison is in progress is ignored and does not change the result in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe; operands captured on this edge when idle |
| acc_i | input | 32 | Accumulator word |
| opd_i | input | 32 | Second word, the value subtracted |
| done_o | output | 1 | One-clock pulse when the flags are updated |
| lgt_o | output | 1 | Logical greater: sum nonzero |
| agt_o | output | 1 | Arithmetic greater: sum positive and nonzero |
| eq_o | output | 1 | Equal: sum zero |

## Verification
The bench builds two copies side by side from the same stimulus. One uses the default digit-serial alignment (ALIGN_ITER=1). The other uses the single-step barrel shifter (ALIGN_ITER=0). Both use the default seven-bit exponent, six-digit fraction and cutoff of 6. Running the two variants together exposes the latency difference of R9 at every exponent gap from 0 to 5. It also shows that both variants give the same flags, including the truncation of negative shifted fractions and the cutoff boundary at gaps 5 and 6. A start raised during a long digit-serial alignment exercises the busy drop of R10.

// File: rtl/hfc_pkg.sv
package hfc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ALIGN = 2'd1,
      ST_SUM   = 2'd2
   } hfc_state_e;

   typedef struct packed {
      logic lgt;
      logic agt;
      logic eq;
   } hfc_flags_t;

endpackage

// File: rtl/hfc_unpack.sv
module hfc_unpack #(
   parameter int EXP_W     = 7,
   parameter int FRAC_W    = 24,
   parameter int MAN_W     = 32,
   parameter bit FLIP_SIGN = 1'b0
) (
   input  logic [EXP_W+FRAC_W:0]    word_i,
   output logic [EXP_W-1:0]         exp_o,
   output logic signed [MAN_W-1:0]  man_o
);
   localparam int PAD_W  = MAN_W - FRAC_W;
   localparam int SIGN_B = EXP_W + FRAC_W;

   if (PAD_W < 2) begin : g_bad_pad
      $error("hfc_unpack: mantissa needs two spare bits above the fraction");
   end

   logic                    neg;
   logic signed [MAN_W-1:0] mag;

   always_comb begin
      neg   = word_i[SIGN_B] ^ FLIP_SIGN;
      exp_o = word_i[FRAC_W +: EXP_W];
      mag   = $signed({{PAD_W{1'b0}}, word_i[FRAC_W-1:0]});
      man_o = neg ? -mag : mag;
   end

endmodule

// File: rtl/hfc_align.sv
module hfc_align #(
   parameter int EXP_W      = 7,
   parameter int MAN_W      = 32,
   parameter int CUTOFF     = 6,
   parameter bit ALIGN_ITER = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load_i,
   input  logic                     step_i,
   input  logic [EXP_W-1:0]         exp_a_i,
   input  logic [EXP_W-1:0]         exp_b_i,
   input  logic signed [MAN_W-1:0]  man_a_i,
   input  logic signed [MAN_W-1:0]  man_b_i,
   output logic signed [MAN_W-1:0]  man_a_o,
   output logic signed [MAN_W-1:0]  man_b_o,
   output logic                     aligned_o
);
   localparam logic [EXP_W-1:0] CUT_V = EXP_W'(CUTOFF);

   logic [EXP_W-1:0]         ea_q, eb_q;
   logic signed [MAN_W-1:0]  ma_q, mb_q;

   logic                     a_big;
   logic [EXP_W-1:0]         gap;
   logic                     drop;
   logic [EXP_W-1:0]         big_e;
   logic signed [MAN_W-1:0]  small_m;
   logic signed [MAN_W-1:0]  small_nx;
   logic [EXP_W-1:0]         small_e_nx;
   logic signed [MAN_W-1:0]  move_m;
   logic [EXP_W-1:0]         move_e;

   always_comb begin
      a_big   = ea_q > eb_q;
      gap     = a_big ? (ea_q - eb_q) : (eb_q - ea_q);
      drop    = gap >= CUT_V;
      big_e   = a_big ? ea_q : eb_q;
      small_m = a_big ? mb_q : ma_q;
   end

   if (ALIGN_ITER) begin : g_iter
      logic [EXP_W-1:0] small_e;
      always_comb begin
         small_e    = a_big ? eb_q : ea_q;
         small_nx   = small_m >>> 4;
         small_e_nx = small_e + EXP_W'(1);
      end
   end else begin : g_barrel
      always_comb begin
         small_nx   = small_m >>> {gap, 2'b00};
         small_e_nx = big_e;
      end
   end

   always_comb begin
      move_m = drop ? '0 : small_nx;
      move_e = drop ? big_e : small_e_nx;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ea_q <= '0;
         eb_q <= '0;
         ma_q <= '0;
         mb_q <= '0;
      end else if (load_i) begin
         ea_q <= exp_a_i;
         eb_q <= exp_b_i;
         ma_q <= man_a_i;
         mb_q <= man_b_i;
      end else if (step_i && !aligned_o) begin
         if (a_big) begin
            mb_q <= move_m;
            eb_q <= move_e;
         end else begin
            ma_q <= move_m;
            ea_q <= move_e;
         end
      end
   end

   assign man_a_o   = ma_q;
   assign man_b_o   = mb_q;
   assign aligned_o = (ea_q == eb_q);

endmodule

// File: rtl/hfc_flags.sv
module hfc_flags
   import hfc_pkg::*;
#(
   parameter int MAN_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     capture_i,
   input  logic signed [MAN_W-1:0]  man_a_i,
   input  logic signed [MAN_W-1:0]  man_b_i,
   output hfc_flags_t               flags_o
);
   logic signed [MAN_W-1:0] sum;
   hfc_flags_t              nx;
   hfc_flags_t              flags_q;

   always_comb begin
      sum    = man_a_i + man_b_i;
      nx.eq  = ~|sum;
      nx.lgt = |sum;
      nx.agt = ~sum[MAN_W-1] & (|sum);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= '0;
      end else if (capture_i) begin
         flags_q <= nx;
      end
   end

   assign flags_o = flags_q;

endmodule

// File: rtl/hfc_compare.sv
module hfc_compare
   import hfc_pkg::*;
#(
   parameter int EXP_W       = 7,
   parameter int FRAC_DIGITS = 6,
   parameter int CUTOFF      = 6,
   parameter bit ALIGN_ITER  = 1'b1,
   localparam int FRAC_W     = 4 * FRAC_DIGITS,
   localparam int WORD_W     = 1 + EXP_W + FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [WORD_W-1:0] acc_i,
   input  logic [WORD_W-1:0] opd_i,
   output logic              done_o,
   output logic              lgt_o,
   output logic              agt_o,
   output logic              eq_o
);
   localparam int MAN_W = FRAC_W + 8;

   if (EXP_W < 2) begin : g_bad_exp
      $error("hfc_compare: EXP_W must be at least 2");
   end
   if (FRAC_DIGITS < 1) begin : g_bad_frac
      $error("hfc_compare: FRAC_DIGITS must be at least 1");
   end
   if (CUTOFF < 1 || CUTOFF >= (1 << EXP_W)) begin : g_bad_cut
      $error("hfc_compare: CUTOFF must lie within the exponent range");
   end

   hfc_state_e              state_q;
   logic                    done_q;
   logic                    load, step, capture, aligned;
   logic [EXP_W-1:0]        exp_a, exp_b;
   logic signed [MAN_W-1:0] man_a, man_b, al_a, al_b;
   hfc_flags_t              flags;

   hfc_unpack #(
      .EXP_W(EXP_W), .FRAC_W(FRAC_W), .MAN_W(MAN_W), .FLIP_SIGN(1'b0)
   ) u_unpack_acc (
      .word_i(acc_i), .exp_o(exp_a), .man_o(man_a)
   );

   hfc_unpack #(
      .EXP_W(EXP_W), .FRAC_W(FRAC_W), .MAN_W(MAN_W), .FLIP_SIGN(1'b1)
   ) u_unpack_opd (
      .word_i(opd_i), .exp_o(exp_b), .man_o(man_b)
   );

   hfc_align #(
      .EXP_W(EXP_W), .MAN_W(MAN_W), .CUTOFF(CUTOFF), .ALIGN_ITER(ALIGN_ITER)
   ) u_align (
      .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step),
      .exp_a_i(exp_a), .exp_b_i(exp_b), .man_a_i(man_a), .man_b_i(man_b),
      .man_a_o(al_a), .man_b_o(al_b), .aligned_o(aligned)
   );

   hfc_flags #(
      .MAN_W(MAN_W)
   ) u_flags (
      .clk(clk), .rst_n(rst_n), .capture_i(capture),
      .man_a_i(al_a), .man_b_i(al_b), .flags_o(flags)
   );

   always_comb begin
      load    = (state_q == ST_IDLE) && start_i;
      step    = (state_q == ST_ALIGN);
      capture = (state_q == ST_SUM);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
      end else begin
         done_q <= capture;
         case (state_q)
            ST_IDLE:  if (start_i) state_q <= ST_ALIGN;
            ST_ALIGN: if (aligned) state_q <= ST_SUM;
            ST_SUM:   state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign done_o = done_q;
   assign lgt_o  = flags.lgt;
   assign agt_o  = flags.agt;
   assign eq_o   = flags.eq;

endmodule

// File: rtl/hfc_compare_chk.sv
module hfc_compare_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] state_i,
   input logic       aligned_i,
   input logic       done_i,
   input logic       lgt_i,
   input logic       agt_i,
   input logic       eq_i
);

   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> !done_i);

   p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !done_i |-> $stable({lgt_i, agt_i, eq_i}));

   p_agt_needs_lgt_r3: assert property (@(posedge clk) disable iff (!rst_n)
      agt_i |-> lgt_i);

   p_eq_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      eq_i |-> (!lgt_i && !agt_i));

   p_result_decided_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |-> (eq_i || lgt_i));

   p_sum_after_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == 2'd2) |-> aligned_i);

endmodule

bind hfc_compare hfc_compare_chk u_hfc_chk (
   .clk(clk), .rst_n(rst_n), .state_i(state_q), .aligned_i(aligned),
   .done_i(done_o), .lgt_i(lgt_o), .agt_i(agt_o), .eq_i(eq_o)
);

// File: tb/hfc_compare_bench.sv
module hfc_compare_bench;
   localparam int CUT = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] acc = '0;
   logic [31:0] opd = '0;
   logic [1:0]  done, lgt, agt, eq;

   hfc_compare u_hfc_compare (
      .clk(clk), .rst_n(rst_n), .start_i(start), .acc_i(acc), .opd_i(opd),
      .done_o(done[0]), .lgt_o(lgt[0]), .agt_o(agt[0]), .eq_o(eq[0])
   );

   hfc_compare #(.ALIGN_ITER(1'b0)) u_hfc_compare_barrel (
      .clk(clk), .rst_n(rst_n), .start_i(start), .acc_i(acc), .opd_i(opd),
      .done_o(done[1]), .lgt_o(lgt[1]), .agt_o(agt[1]), .eq_o(eq[1])
   );

   always #10 clk = ~clk;

   int       n_chk = 0;
   int       n_fail = 0;
   bit       finished = 0;
   string    cur_req = "R1";
   int       cnt [2];
   logic [2:0] pend [2];
   logic [2:0] expf [2];
   logic       exp_done [2];

   // flags packed {lgt, agt, eq}
   function automatic logic [2:0] ref_flags(input logic [31:0] a, input logic [31:0] b);
      int ea, eb, ma, mb, sum;
      ea = int'(a[30:24]);
      eb = int'(b[30:24]);
      ma = int'(a[23:0]);
      if (a[31]) ma = -ma;
      mb = int'(b[23:0]);
      if (!b[31]) mb = -mb;
      if (ea > eb) begin
         if (ea - eb >= CUT) mb = 0; else mb = mb >>> (4 * (ea - eb));
      end else if (eb > ea) begin
         if (eb - ea >= CUT) ma = 0; else ma = ma >>> (4 * (eb - ea));
      end
      sum = ma + mb;
      return {sum != 0, sum > 0, sum == 0};
   endfunction

   function automatic int ref_lat(input logic [31:0] a, input logic [31:0] b, input bit iter);
      int d;
      d = int'(a[30:24]) - int'(b[30:24]);
      if (d < 0) d = -d;
      if (d == 0) return 2;
      if (d >= CUT || !iter) return 3;
      return d + 2;
   endfunction

   always @(posedge clk) begin
      for (int l = 0; l < 2; l++) begin
         if (!rst_n) begin
            cnt[l] = 0;
            expf[l] = 3'b000;
            exp_done[l] = 1'b0;
         end else begin
            exp_done[l] = 1'b0;
            if (cnt[l] > 0) begin
               cnt[l] = cnt[l] - 1;
               if (cnt[l] == 0) begin
                  exp_done[l] = 1'b1;
                  expf[l] = pend[l];
               end
            end else if (start) begin
               cnt[l] = ref_lat(acc, opd, (l == 0));
               pend[l] = ref_flags(acc, opd);
            end
         end
      end
   end

   always @(negedge clk) begin
      if (!finished) begin
         for (int l = 0; l < 2; l++) begin
            n_chk++;
            if (done[l] !== exp_done[l]) begin
               n_fail++;
               $display("FAIL R9 lane %0d done actual %b expected %b", l, done[l], exp_done[l]);
            end
            n_chk++;
            if ({lgt[l], agt[l], eq[l]} !== expf[l]) begin
               n_fail++;
               $display("FAIL %s lane %0d flags actual %b expected %b",
                        cur_req, l, {lgt[l], agt[l], eq[l]}, expf[l]);
            end
         end
      end
   end

   task automatic wait_idle();
      while (cnt[0] != 0 || cnt[1] != 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic run_case(input logic [31:0] a, input logic [31:0] b, input string req);
      @(negedge clk);
      cur_req = req;
      acc = a;
      opd = b;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_idle();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_fail++;
         $display("FAIL R9 watchdog: done actual missing expected within limit");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] seed;
      seed = 32'h1234_5678;
      // R1: outputs quiet during and after reset
      repeat (3) @(negedge clk);
      n_chk++;
      if ({done[0], lgt[0], agt[0], eq[0]} !== 4'b0000) begin
         n_fail++;
         $display("FAIL R1 reset outputs actual %b expected 0000", {done[0], lgt[0], agt[0], eq[0]});
      end
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      run_case(32'h4110_0000, 32'h4110_0000, "R2");
      run_case(32'h4220_0000, 32'h4110_0000, "R3");
      run_case(32'h4110_0000, 32'h4120_0000, "R4");
      run_case(32'h4110_0000, 32'hC110_0000, "R5");
      run_case(32'hC120_0000, 32'hC110_0000, "R5");
      run_case(32'h4110_0000, 32'h40FF_FFFF, "R6");
      run_case(32'h3E12_3456, 32'h4100_0100, "R6");
      run_case(32'hC3AB_CDEF, 32'hC0FF_0000, "R6");
      run_case(32'h4810_0000, 32'h42FF_FFFF, "R7");
      run_case(32'h4710_0000, 32'h42FF_FFFF, "R7");
      run_case(32'h4000_0001, 32'h4600_0001, "R7");
      run_case(32'h0000_0000, 32'h0000_0000, "R8");
      run_case(32'h0000_0000, 32'h4110_0000, "R8");
      run_case(32'h7F00_0000, 32'h4010_0000, "R8");
      run_case(32'h8000_0000, 32'h0000_0000, "R8");
      run_case(32'h0000_0000, 32'h0310_0000, "R8");
      for (int g = 0; g < 8; g++)
         run_case(32'h4080_0000 + (g << 24), 32'h4080_0000, "R9");

      // R10: starts raised while busy are dropped
      @(negedge clk);
      cur_req = "R10";
      acc = 32'h4110_0000;
      opd = 32'h4510_0000;
      start = 1'b1;
      @(negedge clk);
      acc = 32'h4510_0000;
      opd = 32'h4110_0000;
      @(negedge clk);
      @(negedge clk);
      start = 1'b0;
      wait_idle();
      repeat (5) @(negedge clk);

      for (int i = 0; i < 60; i++) begin
         logic [31:0] a, b;
         seed = seed * 32'd1103515245 + 32'd12345;
         a = seed;
         seed = seed * 32'd1103515245 + 32'd12345;
         b = seed;
         if (i % 2 == 0) b[30:24] = a[30:24] + 7'(i % 8);
         if (i % 3 == 0) b[23:12] = a[23:12];
         run_case(a, b, "R4");
      end

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule